// File: doc/BRIEF.md
# Two-Wire Byte Receiver with Address-Match Wake-Up

This block receives bytes over a two-wire serial link, most significant bit first, into an 8-bit shift register. After each completed byte it can raise a transfer-complete interrupt. A programmable slave-address register is compared continuously with the shift register, and the result is visible as a read-only flag in the control register. The shift clock comes from one of three sources: the external clock pin, a timer output divided by sixteen, or a prescaler clock. Every clock source and both data pins pass through a two-flop synchroniser into the system clock domain. Data is sampled on the rising edge of the selected shift clock.

A wake-up mode lets the surrounding logic stay idle while bus traffic for other devices goes by. In this mode the per-byte interrupt is held back. It fires only when the first byte after a start condition equals the stored address. Start detection comes in as a one-cycle strobe from outside. While wake-up is on, software writes to the shift register are dropped and reported with a one-cycle flag. Two receive encodings choose which of the two data pins carries the data. The other pin is reported as free for general use.

Top module: `sadr_wake_rx`

## Requirements
- R1: After reset the control register reads 0x00, the shift register reads 0x00, and `xfer_irq` and `shreg_wr_blocked` are low.
- R2: A control write stores bit 7 (enable), bit 5 (wake-up) and bits 4..0 (receive mode in 4..2, clock select in 1..0). Bit 6 of the written value is ignored. Bit 6 of the readback is the compare flag.
- R3: The compare flag reads 1 exactly when the unit is enabled and the address register equals the shift register. It reads 0 whenever bit 7 is 0.
- R4: When clock-select bit 1 is 0, the shift clock is the external clock pin, whatever the value of bit 0. One bit is shifted per rising edge, seen after the two-flop synchroniser.
- R5: Clock select 10 shifts one bit on every sixteenth rising edge of the timer input. The divider restarts from zero while the unit is disabled.
- R6: Clock select 11 shifts one bit per rising edge of the prescaler clock input.
- R7: Receive needs mode bit 4 = 1. Mode bit 3 = 1 takes data from `sda_a`, and mode bit 3 = 0 takes it from `sda_b`. Mode bit 2 is don't-care. Bytes enter MSB first. `dpin_free` bit 0 (pin A) or bit 1 (pin B) is 0 for the pin in use. Both bits are 1 when mode bit 4 is 0.
- R8: With wake-up off, `xfer_irq` is a one-cycle pulse after every eighth shifted bit.
- R9: With wake-up on, `xfer_irq` pulses only when the first complete byte after a start strobe equals the address register. Later bytes, and bytes with no start before them, raise nothing.
- R10: A start strobe on an enabled unit resets the bit counter and arms the first-byte qualifier. The qualifier clears once a byte completes.
- R11: While wake-up is on, a shift-register write leaves the register unchanged and gives a one-cycle `shreg_wr_blocked` pulse.
- R12: Clearing the enable bit abandons a partly received byte and resets the bit counter. No interrupt is raised while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| addr_wr_en | input | 1 | Address register write strobe |
| addr_wr_data | input | 8 | Address register write value |
| shreg_wr_en | input | 1 | Shift register write strobe |
| shreg_wr_data | input | 8 | Shift register write value |
| scl_pin | input | 1 | External shift clock pin |
| tmr_out | input | 1 | Timer output, divided by 16 when selected |
| presc_clk | input | 1 | Prescaler clock |
| sda_a | input | 1 | Data pin A |
| sda_b | input | 1 | Data pin B |
| start_det | input | 1 | Start-condition strobe, one system cycle |
| ctl_rd_data | output | 8 | Control register readback with compare flag in bit 6 |
| shreg_rd_data | output | 8 | Shift register contents |
| xfer_irq | output | 1 | Transfer-complete interrupt pulse |
| shreg_wr_blocked | output | 1 | Pulse marking a dropped shift-register write |
| dpin_free | output | 2 | Bit 0: pin A free; bit 1: pin B free |

## Verification
A fault in the bit counter shows up at the ports within one byte time, as an interrupt that comes early, late or not at all. A bad first-byte qualifier shows up in wake-up mode as an interrupt for a non-matching byte or a missing one for a match. An error in the synchroniser or the divider shifts the sampling point. That gives a wrong bit in `shreg_rd_data` and an interrupt a few cycles off, and the reference model, compared on every clock, catches it in the same cycle. The compare flag depends only on register state, so a stale address or shift value shows in `ctl_rd_data` bit 6 on the next cycle.

// File: rtl/sadr_pkg.sv
package sadr_pkg;

    typedef enum logic [1:0] {
        CKS_EXT_A = 2'b00,
        CKS_EXT_B = 2'b01,
        CKS_TMR   = 2'b10,
        CKS_PRE   = 2'b11
    } cks_e;

    typedef struct packed {
        logic       en;
        logic       wake;
        logic [2:0] mode;
        logic [1:0] cks;
    } ctl_t;

    localparam int CTL_W      = 8;
    localparam int MODE_RX    = 2;
    localparam int MODE_PIN_A = 1;

endpackage

// File: rtl/sadr_sync.sv
module sadr_sync #(
    parameter int STAGES = 2,
    parameter bit RISE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LEN = STAGES + (RISE ? 1 : 0);

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    generate
        if (RISE) begin : g_rise
            assign dout = sh_q[STAGES-1] & ~sh_q[STAGES];
        end else begin : g_lvl
            assign dout = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sadr_clksel.sv
module sadr_clksel
    import sadr_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] cks,
    input  logic       ext_rise,
    input  logic       tmr_rise,
    input  logic       pre_rise,
    output logic       tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tmr_tick;

    always_comb begin
        cnt_d    = cnt_q;
        tmr_tick = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (tmr_rise) begin
            tmr_tick = (cnt_q == LAST);
            cnt_d    = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
        case (cks_e'(cks))
            CKS_TMR: tick = tmr_tick;
            CKS_PRE: tick = pre_rise;
            default: tick = ext_rise;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sadr_wake_rx.sv
module sadr_wake_rx
    import sadr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TMR_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr_en,
    input  logic [7:0]    ctl_wr_data,
    input  logic          addr_wr_en,
    input  logic [DW-1:0] addr_wr_data,
    input  logic          shreg_wr_en,
    input  logic [DW-1:0] shreg_wr_data,
    input  logic          scl_pin,
    input  logic          tmr_out,
    input  logic          presc_clk,
    input  logic          sda_a,
    input  logic          sda_b,
    input  logic          start_det,
    output logic [7:0]    ctl_rd_data,
    output logic [DW-1:0] shreg_rd_data,
    output logic          xfer_irq,
    output logic          shreg_wr_blocked,
    output logic [1:0]    dpin_free
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);
    localparam int N_CLK = 3;
    localparam int N_IN  = 5;

    typedef struct packed {
        ctl_t          ctl;
        logic [DW-1:0] addr;
        logic [DW-1:0] shreg;
        logic [BW-1:0] bitcnt;
        logic          first;
        logic          irq;
        logic          blk;
    } state_t;

    state_t d, q;

    logic [N_IN-1:0] raw_in, sync_out;
    logic            tick, din;
    logic [DW-1:0]   shifted;

    assign raw_in = {sda_b, sda_a, presc_clk, tmr_out, scl_pin};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_sync
            sadr_sync #(
                .STAGES (SYNC_STAGES),
                .RISE   (i < N_CLK)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_in[i]),
                .dout  (sync_out[i])
            );
        end
    endgenerate

    sadr_clksel #(.DIV(TMR_DIV)) u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.ctl.en),
        .cks      (q.ctl.cks),
        .ext_rise (sync_out[0]),
        .tmr_rise (sync_out[1]),
        .pre_rise (sync_out[2]),
        .tick     (tick)
    );

    assign din     = q.ctl.mode[MODE_PIN_A] ? sync_out[3] : sync_out[4];
    assign shifted = {q.shreg[DW-2:0], din};

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        d.blk = 1'b0;

        if (ctl_wr_en) begin
            d.ctl.en   = ctl_wr_data[7];
            d.ctl.wake = ctl_wr_data[5];
            d.ctl.mode = ctl_wr_data[4:2];
            d.ctl.cks  = ctl_wr_data[1:0];
        end

        if (addr_wr_en) d.addr = addr_wr_data;

        if (shreg_wr_en) begin
            if (q.ctl.wake) d.blk   = 1'b1;
            else            d.shreg = shreg_wr_data;
        end

        if (!q.ctl.en) begin
            d.bitcnt = '0;
            d.first  = 1'b0;
        end else if (start_det) begin
            d.bitcnt = '0;
            d.first  = 1'b1;
        end else if (tick && q.ctl.mode[MODE_RX]) begin
            d.shreg = shifted;
            if (q.bitcnt == LAST_BIT) begin
                d.bitcnt = '0;
                d.first  = 1'b0;
                d.irq    = q.ctl.wake ? (q.first && (shifted == q.addr)) : 1'b1;
            end else begin
                d.bitcnt = q.bitcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rd_data      = {q.ctl.en, q.ctl.en && (q.addr == q.shreg),
                               q.ctl.wake, q.ctl.mode, q.ctl.cks};
    assign shreg_rd_data    = q.shreg;
    assign xfer_irq         = q.irq;
    assign shreg_wr_blocked = q.blk;
    assign dpin_free        = !q.ctl.mode[MODE_RX]   ? 2'b11 :
                              q.ctl.mode[MODE_PIN_A] ? 2'b10 : 2'b01;
endmodule

// File: rtl/sadr_wake_rx_chk.sv
module sadr_wake_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_en,
    input logic [7:0] ctl_wr_data,
    input logic       addr_wr_en,
    input logic       shreg_wr_en,
    input logic [7:0] ctl_rd_data,
    input logic       xfer_irq,
    input logic       shreg_wr_blocked
);
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |=> !xfer_irq);

    assert_flag_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd_data[7] |-> !ctl_rd_data[6]);

    assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> ({ctl_rd_data[7], ctl_rd_data[5:0]} ==
                       {$past(ctl_wr_data[7]), $past(ctl_wr_data[5:0])}));

    assert_wr_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shreg_wr_en && ctl_rd_data[5]) |=> shreg_wr_blocked);

    assert_blk_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        shreg_wr_blocked |-> ($past(shreg_wr_en) && $past(ctl_rd_data[5])));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd_data[7] |=> !xfer_irq);

    assert_wake_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_irq && $past(ctl_rd_data[5]) && ctl_rd_data[7] && !$past(addr_wr_en))
            |-> ctl_rd_data[6]);
endmodule

bind sadr_wake_rx sadr_wake_rx_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ctl_wr_en        (ctl_wr_en),
    .ctl_wr_data      (ctl_wr_data),
    .addr_wr_en       (addr_wr_en),
    .shreg_wr_en      (shreg_wr_en),
    .ctl_rd_data      (ctl_rd_data),
    .xfer_irq         (xfer_irq),
    .shreg_wr_blocked (shreg_wr_blocked)
);

// File: tb/sadr_wake_rx_test.sv
`timescale 1ns/1ps
module sadr_wake_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 0, addr_wr_en = 0, shreg_wr_en = 0;
    logic [7:0] ctl_wr_data = 0, addr_wr_data = 0, shreg_wr_data = 0;
    logic       scl_pin = 0, tmr_out = 0, presc_clk = 0, sda_a = 0, sda_b = 0, start_det = 0;
    logic [7:0] ctl_rd_data, shreg_rd_data;
    logic       xfer_irq, shreg_wr_blocked;
    logic [1:0] dpin_free;

    int checks = 0, errors = 0, irq_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sadr_wake_rx uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
        .shreg_wr_en(shreg_wr_en), .shreg_wr_data(shreg_wr_data),
        .scl_pin(scl_pin), .tmr_out(tmr_out), .presc_clk(presc_clk),
        .sda_a(sda_a), .sda_b(sda_b), .start_det(start_det),
        .ctl_rd_data(ctl_rd_data), .shreg_rd_data(shreg_rd_data),
        .xfer_irq(xfer_irq), .shreg_wr_blocked(shreg_wr_blocked),
        .dpin_free(dpin_free)
    );

    // behavioural reference model
    bit       m_en, m_wake, m_first, m_irq, m_blk;
    bit [2:0] m_mode;
    bit [1:0] m_cks;
    bit [7:0] m_addr, m_sh;
    int       m_bc, m_tc;
    bit [2:0] hs, ht, hp, ha, hb;   // [0]=last edge, [1]=two edges back, [2]=three back

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_wake = 0; m_first = 0; m_irq = 0; m_blk = 0;
            m_mode = 0; m_cks = 0; m_addr = 0; m_sh = 0; m_bc = 0; m_tc = 0;
            hs = 0; ht = 0; hp = 0; ha = 0; hb = 0;
        end else begin
            bit sr, tr, pr, tt, tick, din;
            bit n_en, n_wake, n_first, n_irq, n_blk;
            bit [2:0] n_mode; bit [1:0] n_cks; bit [7:0] n_addr, n_sh, nv;
            int n_bc, n_tc;
            sr = hs[1] & ~hs[2]; tr = ht[1] & ~ht[2]; pr = hp[1] & ~hp[2];
            tt = 0; n_tc = m_tc;
            if (!m_en) n_tc = 0;
            else if (tr) begin tt = (m_tc == 15); n_tc = (m_tc + 1) % 16; end
            tick = !m_cks[1] ? sr : (m_cks[0] ? pr : tt);
            din  = m_mode[1] ? ha[1] : hb[1];
            n_en = m_en; n_wake = m_wake; n_mode = m_mode; n_cks = m_cks;
            n_addr = m_addr; n_sh = m_sh; n_bc = m_bc; n_first = m_first;
            n_irq = 0; n_blk = 0;
            if (ctl_wr_en) begin
                n_en = ctl_wr_data[7]; n_wake = ctl_wr_data[5];
                n_mode = ctl_wr_data[4:2]; n_cks = ctl_wr_data[1:0];
            end
            if (addr_wr_en) n_addr = addr_wr_data;
            if (shreg_wr_en) begin
                if (m_wake) n_blk = 1; else n_sh = shreg_wr_data;
            end
            if (!m_en) begin n_bc = 0; n_first = 0; end
            else if (start_det) begin n_bc = 0; n_first = 1; end
            else if (tick && m_mode[2]) begin
                nv = {m_sh[6:0], din}; n_sh = nv;
                if (m_bc == 7) begin
                    n_bc = 0; n_first = 0;
                    n_irq = m_wake ? (m_first && nv == m_addr) : 1'b1;
                end else n_bc = m_bc + 1;
            end
            m_en = n_en; m_wake = n_wake; m_mode = n_mode; m_cks = n_cks;
            m_addr = n_addr; m_sh = n_sh; m_bc = n_bc; m_first = n_first;
            m_irq = n_irq; m_blk = n_blk; m_tc = n_tc;
            hs = {hs[1:0], scl_pin}; ht = {ht[1:0], tmr_out}; hp = {hp[1:0], presc_clk};
            ha = {ha[1:0], sda_a};   hb = {hb[1:0], sda_b};
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [7:0] e_ctl; bit [1:0] e_free;
            e_ctl  = {m_en, m_en && (m_addr == m_sh), m_wake, m_mode, m_cks};
            e_free = !m_mode[2] ? 2'b11 : (m_mode[1] ? 2'b10 : 2'b01);
            check("R2 R3 ctl_rd_data", ctl_rd_data, e_ctl);
            check("R4 R5 R6 R7 shreg_rd_data", shreg_rd_data, m_sh);
            check("R8 R9 R10 R12 xfer_irq", xfer_irq, m_irq);
            check("R11 shreg_wr_blocked", shreg_wr_blocked, m_blk);
            check("R7 dpin_free", dpin_free, e_free);
            if (xfer_irq) irq_cnt++;
        end
    end

    task automatic wr_ctl(logic [7:0] v);
        ctl_wr_en = 1; ctl_wr_data = v; @(negedge clk); ctl_wr_en = 0; @(negedge clk);
    endtask
    task automatic wr_addr(logic [7:0] v);
        addr_wr_en = 1; addr_wr_data = v; @(negedge clk); addr_wr_en = 0; @(negedge clk);
    endtask
    task automatic wr_sh(logic [7:0] v);
        shreg_wr_en = 1; shreg_wr_data = v; @(negedge clk); shreg_wr_en = 0; @(negedge clk);
    endtask
    task automatic do_start();
        start_det = 1; @(negedge clk); start_det = 0; @(negedge clk);
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // pin: 0 = A, 1 = B; src: 0 = external, 1 = timer, 2 = prescaler
    task automatic drive_bit(bit v, int pin, int src);
        if (pin == 0) begin sda_a = v; sda_b = ~v; end
        else          begin sda_b = v; sda_a = ~v; end
        @(negedge clk);
        case (src)
            0: begin idle(2); scl_pin = 1; idle(3); scl_pin = 0; idle(1); end
            1: repeat (16) begin tmr_out = 1; @(negedge clk); tmr_out = 0; @(negedge clk); end
            default: begin presc_clk = 1; @(negedge clk); presc_clk = 0; @(negedge clk); end
        endcase
    endtask
    task automatic send_bits(logic [7:0] v, int n, int pin, int src);
        for (int i = 7; i > 7 - n; i--) drive_bit(v[i], pin, src);
        idle(5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int base;
        idle(5);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset ctl", ctl_rd_data, 8'h00);
        check("R1 reset shreg", shreg_rd_data, 8'h00);
        check("R1 reset irq", xfer_irq, 0);

        // R2 bit 6 write ignored, R3 flag
        wr_ctl(8'hBF);
        check("R2 R3 ctl readback flag set", ctl_rd_data, 8'hFF);
        wr_addr(8'h5A);
        check("R3 flag clears on mismatch", ctl_rd_data, 8'hBF);
        wr_sh(8'h5A);
        check("R11 blocked write keeps shreg", shreg_rd_data, 8'h00);
        wr_ctl(8'h00);
        wr_addr(8'h00);
        check("R3 flag zero when disabled", ctl_rd_data[6], 0);
        wr_sh(8'h11);
        check("R11 write accepted with wake off", shreg_rd_data, 8'h11);

        // R4 R7 R8 external clock, pin A
        wr_ctl(8'h98);
        check("R7 pin A in use", dpin_free, 2'b10);
        base = irq_cnt;
        send_bits(8'hA5, 8, 0, 0);
        check("R4 R7 byte on pin A", shreg_rd_data, 8'hA5);
        check("R8 one irq per byte", irq_cnt - base, 1);
        wr_ctl(8'h99);
        base = irq_cnt;
        send_bits(8'h3C, 8, 0, 0);
        send_bits(8'hC7, 8, 0, 0);
        check("R4 cks bit0 ignored", shreg_rd_data, 8'hC7);
        check("R8 two bytes two irqs", irq_cnt - base, 2);

        // R7 pin B, mode bit 2 don't care
        wr_ctl(8'h94);
        check("R7 pin B in use", dpin_free, 2'b01);
        send_bits(8'h69, 8, 1, 0);
        check("R7 byte on pin B", shreg_rd_data, 8'h69);
        wr_ctl(8'h80);
        check("R7 no receive mode pins free", dpin_free, 2'b11);
        send_bits(8'hFF, 8, 0, 0);
        check("R7 no shift without mode bit 4", shreg_rd_data, 8'h69);

        // R5 timer / 16, R6 prescaler
        wr_ctl(8'h9A);
        base = irq_cnt;
        send_bits(8'hC3, 8, 0, 1);
        check("R5 timer divided byte", shreg_rd_data, 8'hC3);
        check("R5 timer irq", irq_cnt - base, 1);
        wr_ctl(8'h9B);
        send_bits(8'h81, 8, 0, 2);
        check("R6 prescaler byte", shreg_rd_data, 8'h81);

        // R9 R10 wake-up
        wr_addr(8'h5A);
        wr_ctl(8'hB8);
        base = irq_cnt;
        do_start();
        send_bits(8'h5A, 8, 0, 0);
        check("R9 match after start", irq_cnt - base, 1);
        base = irq_cnt;
        send_bits(8'h5A, 8, 0, 0);
        check("R9 match without start silent", irq_cnt - base, 0);
        do_start();
        send_bits(8'h33, 8, 0, 0);
        check("R9 mismatch silent", irq_cnt - base, 0);
        do_start();
        send_bits(8'hF0, 4, 0, 0);
        do_start();
        send_bits(8'h5A, 8, 0, 0);
        check("R10 restart realigns byte", irq_cnt - base, 1);
        wr_sh(8'h00);
        check("R11 wake blocks write", shreg_rd_data, 8'h5A);

        // R12 abort
        wr_ctl(8'h98);
        base = irq_cnt;
        send_bits(8'hE0, 4, 0, 0);
        wr_ctl(8'h18);
        send_bits(8'hAA, 8, 0, 0);
        check("R12 no irq while disabled", irq_cnt - base, 0);
        wr_ctl(8'h98);
        send_bits(8'h96, 8, 0, 0);
        check("R12 counter reset by disable", irq_cnt - base, 1);
        check("R12 byte after abort", shreg_rd_data, 8'h96);

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule